// File: doc/BRIEF.md
# Two-level wide word magnitude comparator

This block decides the unsigned order of two 24-bit words, A and B. It raises exactly one of three flags: A above B, A below B, or A equal to B. The result is purely combinational. It is built from one small cascadable comparator cell, which orders two 4-bit words and can be extended through a three-flag cascade input.

A plain ripple chain of such cells would put six cells in series. Here the cells are arranged in a tree that is only two cells deep.

- **Least significant cell.** It orders bits 3..0. Its cascade input is tied to the "equal" state.
- **Group cells.** Four cells each order a 5-bit group: 8..4, 13..9, 18..14 and 23..19. Each takes the upper four bits of its group on its data pins. The lowest bit of A goes in on the cascade "above" pin and the lowest bit of B on the cascade "below" pin, with cascade "equal" held low.
- **Final cell.** The group cells' "above" and "below" flags become the A and B data bits of the final cell, with the most significant group on the top data pair. The least significant cell feeds the final cell's cascade input.

The number of groups and the cell width are parameters. With the defaults the word is 24 bits wide.

Top module: `wide_mag_cmp`

## Requirements
- R1: For every pair of inputs exactly one of gt_o, lt_o and eq_o is 1.
- R2: gt_o is 1 exactly when a_i is greater than b_i as an unsigned number.
- R3: lt_o is 1 exactly when a_i is less than b_i as an unsigned number.
- R4: eq_o is 1 exactly when a_i and b_i are bit-for-bit identical.
- R5: When the words differ only within bits 3..0, the result is set by those bits alone, through the final cell's cascade path.
- R6: When the most significant difference is the lowest bit of a group (bit 4, 9, 14 or 19), the result follows that bit. This holds even though that bit enters its group cell on the cascade pins.
- R7: A difference in a more significant group decides the result regardless of any differences in less significant groups or in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 24 | First operand, unsigned, bit 23 most significant |
| b_i | input | 24 | Second operand, unsigned, bit 23 most significant |
| gt_o | output | 1 | 1 when a_i is above b_i |
| lt_o | output | 1 | 1 when a_i is below b_i |
| eq_o | output | 1 | 1 when a_i equals b_i |

## Verification
The bench targets single-bit differences at every group edge, in both directions: bits 3, 4, 8, 9, 13, 14, 18, 19 and 23.

- If the cascade "above" and "below" pins were swapped in a group cell, a difference in bit 4, 9, 14 or 19 would invert the result.
- If the final cell's data pairs were placed in the wrong order, a higher-group difference would lose to a lower one.
- If the group cells' behaviour for an all-equal group were wrong, equal words would raise "above" or "below", or all three flags at once.

Equal words, and random vectors checked against an unsigned comparison, cover the rest.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_flags_t;

  localparam cmp_flags_t CASC_START = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
endpackage

// File: rtl/mag_cell.sv
module mag_cell
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_flags_t   casc_i,
  output cmp_flags_t   res_o
);
  logic decided;

  always_comb begin
    // equal data: cascade decides, including the abnormal cascade codes
    res_o.gt = ~casc_i.eq & ~casc_i.lt;
    res_o.lt = ~casc_i.eq & ~casc_i.gt;
    res_o.eq = casc_i.eq;
    decided  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!decided && (a_i[i] != b_i[i])) begin
        res_o.gt = a_i[i];
        res_o.lt = b_i[i];
        res_o.eq = 1'b0;
        decided  = 1'b1;
      end
    end
  end

  // R1: a normal cascade code gives a normal result code
  always_comb begin
    if ($onehot({casc_i.gt, casc_i.lt, casc_i.eq}))
      a_r1_cell_onehot: assert ($onehot({res_o.gt, res_o.lt, res_o.eq}))
        else $error("cell result not one-hot");
  end
endmodule

// File: rtl/grp_cell.sv
module grp_cell
  import cmp_pkg::*;
#(
  parameter int CELL_W = 4,
  localparam int GW = CELL_W + 1
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  output logic          gt_o,
  output logic          lt_o
);
  cmp_flags_t casc;
  cmp_flags_t res;

  always_comb begin
    casc.gt = a_i[0];
    casc.lt = b_i[0];
    casc.eq = 1'b0;
  end

  mag_cell #(.W(CELL_W)) u_cell (
    .a_i   (a_i[GW-1:1]),
    .b_i   (b_i[GW-1:1]),
    .casc_i(casc),
    .res_o (res)
  );

  assign gt_o = res.gt;
  assign lt_o = res.lt;

  // R6: equal groups present an equal pair, unequal groups order correctly
  always_comb begin
    if (a_i == b_i)
      a_r6_equal_group_pair: assert (res.gt == res.lt && !res.eq)
        else $error("equal group gave unequal pair");
    else
      a_r6_group_order: assert (res.gt == (a_i > b_i) && res.lt == (a_i < b_i))
        else $error("group order wrong");
  end
endmodule

// File: rtl/wide_mag_cmp.sv
module wide_mag_cmp
  import cmp_pkg::*;
#(
  parameter  int CELL_W = 4,
  parameter  int NGRP   = 4,
  localparam int GW     = CELL_W + 1,
  localparam int WIDTH  = CELL_W + NGRP * GW
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  cmp_flags_t      low_res;
  cmp_flags_t      fin_res;
  logic [NGRP-1:0] grp_gt;
  logic [NGRP-1:0] grp_lt;

  mag_cell #(.W(CELL_W)) u_low (
    .a_i   (a_i[CELL_W-1:0]),
    .b_i   (b_i[CELL_W-1:0]),
    .casc_i(CASC_START),
    .res_o (low_res)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = CELL_W + g * GW;
    grp_cell #(.CELL_W(CELL_W)) u_grp (
      .a_i (a_i[LO +: GW]),
      .b_i (b_i[LO +: GW]),
      .gt_o(grp_gt[g]),
      .lt_o(grp_lt[g])
    );
  end

  mag_cell #(.W(NGRP)) u_final (
    .a_i   (grp_gt),
    .b_i   (grp_lt),
    .casc_i(low_res),
    .res_o (fin_res)
  );

  assign gt_o = fin_res.gt;
  assign lt_o = fin_res.lt;
  assign eq_o = fin_res.eq;

  always_comb begin
    a_r1_onehot: assert ($onehot({gt_o, lt_o, eq_o}))
      else $error("R1 result not one-hot");
    a_r2_gt: assert (gt_o == (a_i > b_i))
      else $error("R2 greater flag wrong");
    a_r3_lt: assert (lt_o == (a_i < b_i))
      else $error("R3 less flag wrong");
    a_r4_eq: assert (eq_o == (a_i == b_i))
      else $error("R4 equal flag wrong");
    if (a_i[WIDTH-1:CELL_W] == b_i[WIDTH-1:CELL_W])
      a_r5_low_decides: assert (fin_res == low_res)
        else $error("R5 low cell not passed through");
  end
endmodule

// File: tb/tb_wide_mag_cmp.sv
module tb_wide_mag_cmp;
  localparam int W = 24;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         gt, lt, eq;
  int           n_chk;
  int           n_fail;
  logic [W-1:0] hist_a[$];
  logic [W-1:0] hist_b[$];

  wide_mag_cmp dut (
    .a_i (a),
    .b_i (b),
    .gt_o(gt),
    .lt_o(lt),
    .eq_o(eq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag);
    logic [2:0] exp_v;
    logic [2:0] got_v;
    exp_v = {a > b, a < b, a == b};
    got_v = {gt, lt, eq};
    n_chk++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h got gt/lt/eq=%b expected %b", tag, a, b, got_v, exp_v);
    end
  endtask

  // inputs change just after a rising edge, outputs are sampled at the falling edge
  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
    @(posedge clk);
    #0.5;
    a = va;
    b = vb;
    hist_a.push_back(va);
    hist_b.push_back(vb);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bitpos[9] = '{3, 4, 8, 9, 13, 14, 18, 19, 23};
    logic [W-1:0] r;
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    a      = '0;
    b      = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset state");
    rst_n = 1'b1;

    apply('0, '0, "R4 zeros");
    apply('1, '1, "R4 ones");
    apply(24'hFFFFFF, 24'h0, "R2 max vs zero");
    apply(24'h0, 24'hFFFFFF, "R3 zero vs max");

    for (int k = 0; k < 20; k++) begin
      r = W'($urandom);
      apply(r, r, "R4 equal random");
    end

    foreach (bitpos[k]) begin
      r = W'($urandom);
      r[bitpos[k]] = 1'b0;
      apply(r | (W'(1) << bitpos[k]), r, "R6 boundary bit above");
      apply(r, r | (W'(1) << bitpos[k]), "R6 boundary bit below");
    end

    // differences only in bits 3..0
    for (int k = 0; k < 16; k++) begin
      r = W'($urandom);
      apply(r, {r[W-1:4], 4'(k)}, "R5 low nibble only");
    end

    // a higher group wins over lower groups and over bits 3..0
    apply(24'h080000, 24'h07FFFF, "R7 group3 over lower");
    apply(24'h07FFFF, 24'h080000, "R7 group3 under lower");
    apply(24'h000200, 24'h0001FF, "R7 group1 over lower");
    apply(24'h004000, 24'h003FFF, "R7 group2 over lower");
    apply(24'h000010, 24'h00000F, "R7 group0 over nibble");

    for (int k = 0; k < 3000; k++) begin
      apply(W'($urandom), W'($urandom), "R1 R2 R3 random");
      if (gt + lt + eq != 1) begin
        n_fail++;
        $display("FAIL R1 flags %b%b%b expected one-hot", gt, lt, eq);
      end
      n_chk++;
    end

    // random words that share the upper bits
    for (int k = 0; k < 500; k++) begin
      r = W'($urandom);
      apply(r, r ^ W'($urandom_range(0, 1023)), "R2 R3 close words");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule